// File: doc/BRIEF.md
# Process-State Immediate Write Unit

This unit sits beside an instruction decoder. It recognises a single class of 32-bit system instruction, one that writes a 4-bit immediate into chosen bits of the processor state. In the same cycle it checks privilege, secure state, feature presence and trap configuration. On the following clock edge it either updates the held state flags or raises exactly one outcome pulse. The held flags are four interrupt-mask bits and seven single-bit mode flags. The outcome pulses are undefined-instruction, trap (with target level and syndrome class) and one of three redirect strobes. The redirects hand the instruction to the carry-invert and flag-format conversion operations, which share this encoding space.

Internally an outcome register acts as the state machine. Its states are `ST_IDLE`, `ST_WROTE`, `ST_UNDEF`, `ST_TRAP` and `ST_REDIR`. Every state can move to any other state, chosen by the instruction sampled in the current cycle. The named transitions are:
- *quiet*, to `ST_IDLE`, when no valid matching instruction is present;
- *redirect*, to `ST_REDIR`;
- *reject*, to `ST_UNDEF`, on a privilege, field, feature or immediate failure;
- *trap*, to `ST_TRAP`, on an EL0 interrupt-mask access that is not permitted;
- *commit*, to `ST_WROTE`, otherwise.

The pulse outputs are decoded from the current state alone. Fetch, register access and exception entry belong to other blocks.

Top module: `psi_write_unit`

## Requirements
- R1: While `rst` is sampled high, the unit drives the following on the next edge: `mask_q` = 4'b1111, `mode_q` = 0, and no pulse.
- R2: A word is a candidate only if all of these hold: bits [31:19] = 13'b1101010100000, bits [15:12] = 4'b0100 and bits [4:0] = 5'b11111. Any other word, or any word presented while `instr_valid` is low, changes no flag and raises no pulse.
- R3: With op1 (bits [18:16]) = 0, op2 (bits [7:5]) = 0, 1 or 2 raises `redir_o` bit 0, bit 1 or bit 2 respectively. This takes priority over every other check and leaves all flags unchanged.
- R4: The minimum level depends on op1. op1 of 0, 1, 2 or 7 needs level 1. op1 = 3 needs level 0. op1 = 4 needs level 2. op1 = 6 needs level 3. When `cur_el` is below the minimum, `undef_o` pulses.
- R5: op1 = 5 is always undefined. op1 = 7 is undefined when `secure` is low.
- R6: Field map on {op1,op2}, with the `mode_q` bit in brackets:
  - {0,5}: stack select [0]
  - {0,3}: user-override [1]
  - {0,4}: privileged-no-access [2]
  - {3,1}: speculation-safe [3]
  - {3,2}: timing-independent [4]
  - {3,4}: tag-check override [5]
  - {3,3}: call-stack recording [6]
  - {3,6}: mask set
  - {3,7}: mask clear

  Every other combination is undefined.
- R7: The `feat_en` bits 0 to 5 gate `mode_q` bits 1 to 6 in order. A clear feature bit makes that field undefined. Stack select, mask set and mask clear need no feature bit.
- R8: The call-stack recording field is undefined unless CRm (bits [11:8]) [3:1] = 0.
- R9: A permitted single-bit field write loads CRm[0] into its `mode_q` bit on the edge after `instr_valid` is sampled. No other bit changes.
- R10: `mask_q` bits [3:0] hold the flags D, A, I and F, in that order. Mask set ORs CRm into `mask_q`. Mask clear ANDs `mask_q` with ~CRm.
- R11: At level 0, mask set or mask clear traps when both of these hold: `el1_aa32` is low, and either `user_mask_ok` is low or all of `el2_en`, `host_mode` and `route_hyp` are high. A trap raises `trap_o` with `trap_class_o` = 6'h18. When `trap_o` is low, `trap_class_o` is 0.
- R12: `trap_el_o` is 2 when `el2_en`, `route_hyp` and not `el2_aa32` all hold. Otherwise it is 1.
- R13: Undefined, trap and redirect outcomes leave every flag unchanged. At most one of `undef_o`, `trap_o` and the `redir_o` bits is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Secure state is active |
| feat_en | input | 6 | Feature-present flags for mode bits 1..6 |
| el1_aa32 | input | 1 | Level 1 runs the 32-bit architecture |
| el2_en | input | 1 | Level 2 is enabled |
| el2_aa32 | input | 1 | Level 2 runs the 32-bit architecture |
| host_mode | input | 1 | Hypervisor host-extension control |
| route_hyp | input | 1 | Route general exceptions to level 2 |
| user_mask_ok | input | 1 | Level 0 may touch the interrupt masks |
| mask_q | output | 4 | D, A, I, F interrupt-mask flags |
| mode_q | output | 7 | Single-bit mode flags |
| undef_o | output | 1 | Undefined-instruction pulse |
| trap_o | output | 1 | Trap pulse |
| trap_el_o | output | 2 | Trap target level |
| trap_class_o | output | 6 | Trap syndrome class |
| redir_o | output | 3 | Redirect pulses: carry invert, X-to-A, A-to-X |

## Verification
Two collisions matter. A mask write can also meet the EL0 trap condition, and a redirect encoding can also fail the privilege check. At level 0 the bench issues mask set and mask clear under every combination of the six trap-control inputs, and it sweeps every op1, op2 and CRm at every level. A trap must win over the write, leave `mask_q` intact and report the computed target level. A redirect must win over the privilege failure, with no undefined pulse.

// File: rtl/psi_pkg.sv
package psi_pkg;

    typedef enum logic [3:0] {
        FLD_NONE, FLD_STACK, FLD_UOVR, FLD_PNOACC, FLD_SBSAFE,
        FLD_DITIME, FLD_TAGOVR, FLD_CSREC, FLD_MSET, FLD_MCLR
    } fld_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WROTE, ST_UNDEF, ST_TRAP, ST_REDIR
    } st_e;

    localparam int NUM_MODE = 7;
    localparam int NUM_MASK = 4;
    localparam int NUM_FEAT = NUM_MODE - 1;
    localparam int NUM_REDIR = 3;

    // mode_q bit owned by a single-bit field, or -1 for none
    function automatic int mode_bit(input fld_e f);
        case (f)
            FLD_STACK:  return 0;
            FLD_UOVR:   return 1;
            FLD_PNOACC: return 2;
            FLD_SBSAFE: return 3;
            FLD_DITIME: return 4;
            FLD_TAGOVR: return 5;
            FLD_CSREC:  return 6;
            default:    return -1;
        endcase
    endfunction

endpackage

// File: rtl/psi_decode.sv
module psi_decode
    import psi_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic [IW-1:0]          instr,
    output logic                   hit,
    output logic [2:0]             op1,
    output logic [2:0]             op2,
    output logic [3:0]             crm,
    output logic [NUM_REDIR-1:0]   redir_sel,
    output fld_e                   fld
);
    localparam logic [12:0] HI_PAT  = 13'b1101010100000;
    localparam logic [3:0]  MID_PAT = 4'b0100;
    localparam logic [4:0]  LO_PAT  = 5'b11111;

    always_comb begin
        hit = (instr[31:19] == HI_PAT) && (instr[15:12] == MID_PAT)
              && (instr[4:0] == LO_PAT);
        op1 = instr[18:16];
        crm = instr[11:8];
        op2 = instr[7:5];
    end

    always_comb begin
        redir_sel = '0;
        if (op1 == 3'd0 && op2 < 3'd3)
            redir_sel[op2[1:0]] = 1'b1;
    end

    always_comb begin
        unique case ({op1, op2})
            6'o03:   fld = FLD_UOVR;
            6'o04:   fld = FLD_PNOACC;
            6'o05:   fld = FLD_STACK;
            6'o31:   fld = FLD_SBSAFE;
            6'o32:   fld = FLD_DITIME;
            6'o33:   fld = FLD_CSREC;
            6'o34:   fld = FLD_TAGOVR;
            6'o36:   fld = FLD_MSET;
            6'o37:   fld = FLD_MCLR;
            default: fld = FLD_NONE;
        endcase
    end
endmodule

// File: rtl/psi_gate.sv
module psi_gate
    import psi_pkg::*;
#(
    parameter int EL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  logic                 hit,
    input  logic [2:0]           op1,
    input  logic [3:0]           crm,
    input  logic [NUM_REDIR-1:0] redir_sel,
    input  fld_e                 fld,
    input  logic [EL_W-1:0]      cur_el,
    input  logic                 secure,
    input  logic [NUM_FEAT-1:0]  feat_en,
    input  logic                 el1_aa32,
    input  logic                 el2_en,
    input  logic                 el2_aa32,
    input  logic                 host_mode,
    input  logic                 route_hyp,
    input  logic                 user_mask_ok,
    output st_e                  next_st,
    output logic [EL_W-1:0]      trap_el_n
);
    logic [EL_W-1:0] min_el;
    logic            forbid, need_sec, priv_ok, field_ok, is_mask, trap_hit;

    always_comb begin
        forbid = 1'b0;
        need_sec = 1'b0;
        unique case (op1)
            3'd3:    min_el = EL_W'(0);
            3'd4:    min_el = EL_W'(2);
            3'd5:    begin min_el = EL_W'(0); forbid = 1'b1; end
            3'd6:    min_el = EL_W'(3);
            3'd7:    begin min_el = EL_W'(1); need_sec = 1'b1; end
            default: min_el = EL_W'(1);
        endcase
        priv_ok = !forbid && (cur_el >= min_el) && (!need_sec || secure);
    end

    always_comb begin
        unique case (fld)
            FLD_STACK, FLD_MSET, FLD_MCLR: field_ok = 1'b1;
            FLD_UOVR:   field_ok = feat_en[0];
            FLD_PNOACC: field_ok = feat_en[1];
            FLD_SBSAFE: field_ok = feat_en[2];
            FLD_DITIME: field_ok = feat_en[3];
            FLD_TAGOVR: field_ok = feat_en[4];
            FLD_CSREC:  field_ok = feat_en[5] && (crm[3:1] == 3'd0);
            default:    field_ok = 1'b0;
        endcase
    end

    always_comb begin
        is_mask   = (fld == FLD_MSET) || (fld == FLD_MCLR);
        trap_hit  = is_mask && (cur_el == '0) && !el1_aa32
                    && ((el2_en && host_mode && route_hyp) || !user_mask_ok);
        trap_el_n = (el2_en && !el2_aa32 && route_hyp) ? EL_W'(2) : EL_W'(1);
    end

    always_comb begin
        next_st = ST_IDLE;
        if (valid && hit) begin
            if (|redir_sel)     next_st = ST_REDIR;
            else if (!priv_ok)  next_st = ST_UNDEF;
            else if (!field_ok) next_st = ST_UNDEF;
            else if (trap_hit)  next_st = ST_TRAP;
            else                next_st = ST_WROTE;
        end
    end

    // R5: reserved op1 never commits or traps
    p_reserved_op1_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && hit && op1 == 3'd5) |-> (next_st == ST_UNDEF));
    // R11: traps only originate at level 0
    p_trap_level0_r11: assert property (@(posedge clk) disable iff (rst)
        (next_st == ST_TRAP) |-> (cur_el == '0));
    // R2: non-candidate words produce no outcome
    p_quiet_nonmatch_r2: assert property (@(posedge clk) disable iff (rst)
        (!valid || !hit) |-> (next_st == ST_IDLE));
endmodule

// File: rtl/psi_state.sv
module psi_state
    import psi_pkg::*;
#(
    parameter int EL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  st_e                  next_st,
    input  fld_e                 fld,
    input  logic [3:0]           crm,
    input  logic [EL_W-1:0]      trap_el_n,
    input  logic [NUM_REDIR-1:0] redir_sel,
    output logic [NUM_MASK-1:0]  mask_q,
    output logic [NUM_MODE-1:0]  mode_q,
    output logic                 undef_o,
    output logic                 trap_o,
    output logic [EL_W-1:0]      trap_el_o,
    output logic [NUM_REDIR-1:0] redir_o
);
    st_e                  st_q;
    logic [EL_W-1:0]      tel_q;
    logic [NUM_REDIR-1:0] rsel_q;
    logic [NUM_MODE-1:0]  mode_n;
    logic [NUM_MASK-1:0]  mask_n;
    logic                 commit;

    assign commit = (next_st == ST_WROTE);

    for (genvar k = 0; k < NUM_MODE; k++) begin : g_mode
        assign mode_n[k] = (commit && mode_bit(fld) == k) ? crm[0] : mode_q[k];
    end

    always_comb begin
        mask_n = mask_q;
        if (commit && fld == FLD_MSET) mask_n = mask_q | crm[NUM_MASK-1:0];
        if (commit && fld == FLD_MCLR) mask_n = mask_q & ~crm[NUM_MASK-1:0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            tel_q  <= '0;
            rsel_q <= '0;
            mask_q <= '1;
            mode_q <= '0;
        end else begin
            st_q   <= next_st;
            tel_q  <= trap_el_n;
            rsel_q <= redir_sel;
            mask_q <= mask_n;
            mode_q <= mode_n;
        end
    end

    // outputs decoded from the state
    always_comb begin
        undef_o   = 1'b0;
        trap_o    = 1'b0;
        trap_el_o = '0;
        redir_o   = '0;
        unique case (st_q)
            ST_UNDEF: undef_o = 1'b1;
            ST_TRAP:  begin trap_o = 1'b1; trap_el_o = tel_q; end
            ST_REDIR: redir_o = rsel_q;
            default:  ;
        endcase
    end

    // R1
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && mode_q == '0 && !undef_o && !trap_o && redir_o == '0));
    // R13: no flag movement on a non-write outcome
    p_hold_flags_r13: assert property (@(posedge clk) disable iff (rst)
        (undef_o || trap_o || (|redir_o)) |-> (mask_q == $past(mask_q) && mode_q == $past(mode_q)));
    // R13: exclusive pulses
    p_one_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({undef_o, trap_o, |redir_o}) && $onehot0(redir_o));
    // R10: mask set leaves every requested bit high
    p_mask_set_r10: assert property (@(posedge clk) disable iff (rst)
        (commit && fld == FLD_MSET) |=> ((mask_q & $past(crm)) == $past(crm)));
    // R10: mask clear leaves every requested bit low
    p_mask_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (commit && fld == FLD_MCLR) |=> ((mask_q & $past(crm)) == '0));
endmodule

// File: rtl/psi_write_unit.sv
module psi_write_unit
    import psi_pkg::*;
#(
    parameter int          EL_W       = 2,
    parameter int          CLASS_W    = 6,
    parameter logic [5:0]  TRAP_CLASS = 6'h18
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  instr_valid,
    input  logic [31:0]           instr,
    input  logic [EL_W-1:0]       cur_el,
    input  logic                  secure,
    input  logic [5:0]            feat_en,
    input  logic                  el1_aa32,
    input  logic                  el2_en,
    input  logic                  el2_aa32,
    input  logic                  host_mode,
    input  logic                  route_hyp,
    input  logic                  user_mask_ok,
    output logic [3:0]            mask_q,
    output logic [6:0]            mode_q,
    output logic                  undef_o,
    output logic                  trap_o,
    output logic [EL_W-1:0]       trap_el_o,
    output logic [CLASS_W-1:0]    trap_class_o,
    output logic [2:0]            redir_o
);
    logic                 hit;
    logic [2:0]           op1, op2;
    logic [3:0]           crm;
    logic [NUM_REDIR-1:0] redir_sel;
    fld_e                 fld;
    st_e                  next_st;
    logic [EL_W-1:0]      trap_el_n;

    psi_decode #(.IW(32)) u_dec (
        .instr(instr), .hit(hit), .op1(op1), .op2(op2), .crm(crm),
        .redir_sel(redir_sel), .fld(fld)
    );

    psi_gate #(.EL_W(EL_W)) u_gate (
        .clk(clk), .rst(rst), .valid(instr_valid), .hit(hit), .op1(op1),
        .crm(crm), .redir_sel(redir_sel), .fld(fld), .cur_el(cur_el),
        .secure(secure), .feat_en(feat_en), .el1_aa32(el1_aa32),
        .el2_en(el2_en), .el2_aa32(el2_aa32), .host_mode(host_mode),
        .route_hyp(route_hyp), .user_mask_ok(user_mask_ok),
        .next_st(next_st), .trap_el_n(trap_el_n)
    );

    psi_state #(.EL_W(EL_W)) u_state (
        .clk(clk), .rst(rst), .next_st(next_st), .fld(fld), .crm(crm),
        .trap_el_n(trap_el_n), .redir_sel(redir_sel), .mask_q(mask_q),
        .mode_q(mode_q), .undef_o(undef_o), .trap_o(trap_o),
        .trap_el_o(trap_el_o), .redir_o(redir_o)
    );

    assign trap_class_o = trap_o ? CLASS_W'(TRAP_CLASS) : '0;

    // R11 / R12: trap target is always level 1 or 2
    p_trap_target_r12: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> (trap_el_o == EL_W'(1) || trap_el_o == EL_W'(2)));
endmodule

// File: tb/tb_psi_write_unit.sv
module tb_psi_write_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [1:0]  cur_el = '0;
    logic        secure = 1'b0;
    logic [5:0]  feat_en = '0;
    logic        el1_aa32 = 1'b0, el2_en = 1'b0, el2_aa32 = 1'b0;
    logic        host_mode = 1'b0, route_hyp = 1'b0, user_mask_ok = 1'b1;
    logic [3:0]  mask_q;
    logic [6:0]  mode_q;
    logic        undef_o, trap_o;
    logic [1:0]  trap_el_o;
    logic [5:0]  trap_class_o;
    logic [2:0]  redir_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [3:0] em;
    logic [6:0] es;

    always #5 clk = ~clk;

    psi_write_unit dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .cur_el(cur_el), .secure(secure), .feat_en(feat_en),
        .el1_aa32(el1_aa32), .el2_en(el2_en), .el2_aa32(el2_aa32),
        .host_mode(host_mode), .route_hyp(route_hyp),
        .user_mask_ok(user_mask_ok), .mask_q(mask_q), .mode_q(mode_q),
        .undef_o(undef_o), .trap_o(trap_o), .trap_el_o(trap_el_o),
        .trap_class_o(trap_class_o), .redir_o(redir_o)
    );

    function automatic logic [31:0] mk(input logic [2:0] o1, input logic [3:0] c,
                                       input logic [2:0] o2);
        return {13'b1101010100000, o1, 4'b0100, c, o2, 5'b11111};
    endfunction

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one word with a given valid, compute the expected result, and compare
    task automatic issue(input logic [31:0] w, input logic v, input logic [1:0] el,
                         input logic sec, input logic [5:0] fe, input logic [5:0] cfg);
        logic [2:0] o1, o2;
        logic [3:0] c;
        logic is_hit, u, t, ok, want_sec;
        logic [1:0] tel, need;
        logic [2:0] rd;
        int sel;  // 0..6 mode bit, 7 set, 8 clear, -1 none
        string req;
        o1 = w[18:16]; o2 = w[7:5]; c = w[11:8];
        is_hit = v && w[31:19] == 13'b1101010100000 && w[15:12] == 4'b0100 && w[4:0] == 5'b11111;
        u = 0; t = 0; tel = 0; rd = 0; req = "R2";
        @(negedge clk);
        instr = w; instr_valid = v; cur_el = el; secure = sec; feat_en = fe;
        {user_mask_ok, route_hyp, host_mode, el2_aa32, el2_en, el1_aa32} = cfg;
        if (is_hit) begin
            if (o1 == 0 && o2 <= 2) begin
                rd = 3'b001 << o2; req = "R3";
            end else begin
                need = (o1 == 3) ? 2'd0 : (o1 == 4) ? 2'd2 : (o1 == 6) ? 2'd3 : 2'd1;
                want_sec = (o1 == 7);
                sel = -1; ok = 1;
                if (o1 == 0 && o2 == 5) sel = 0;
                else if (o1 == 0 && o2 == 3) begin sel = 1; ok = fe[0]; end
                else if (o1 == 0 && o2 == 4) begin sel = 2; ok = fe[1]; end
                else if (o1 == 3 && o2 == 1) begin sel = 3; ok = fe[2]; end
                else if (o1 == 3 && o2 == 2) begin sel = 4; ok = fe[3]; end
                else if (o1 == 3 && o2 == 4) begin sel = 5; ok = fe[4]; end
                else if (o1 == 3 && o2 == 3) begin sel = 6; ok = fe[5] && c[3:1] == 0; end
                else if (o1 == 3 && o2 == 6) sel = 7;
                else if (o1 == 3 && o2 == 7) sel = 8;
                if (o1 == 5 || (want_sec && !sec)) begin u = 1; req = "R5"; end
                else if (el < need) begin u = 1; req = "R4"; end
                else if (sel < 0) begin u = 1; req = "R6"; end
                else if (!ok) begin u = 1; req = (sel == 6 && fe[5]) ? "R8" : "R7"; end
                else if (sel >= 7 && el == 0 && !cfg[0]
                         && ((cfg[1] && cfg[3] && cfg[4]) || !cfg[5])) begin
                    t = 1; req = "R11";
                    tel = (cfg[1] && !cfg[2] && cfg[4]) ? 2'd2 : 2'd1;
                end else if (sel == 7) begin em = em | c; req = "R10"; end
                else if (sel == 8) begin em = em & ~c; req = "R10"; end
                else begin es[sel] = c[0]; req = "R9"; end
            end
        end
        @(negedge clk);
        instr_valid = 0;
        check(req, {mask_q, mode_q, undef_o, trap_o, trap_el_o, trap_class_o, redir_o, 3'b0},
              {em, es, u, t, tel, (t ? 6'h18 : 6'h00), rd, 3'b0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {mask_q, mode_q, undef_o, trap_o, trap_el_o, trap_class_o, redir_o, 3'b0},
              {4'hF, 7'h0, 1'b0, 1'b0, 2'd0, 6'h0, 3'b0, 3'b0});
        rst = 0;
        em = 4'hF; es = 7'h0;
        // R2: near-miss words and invalid strobe
        issue(mk(3, 4'hF, 7) ^ 32'h0000_0001, 1, 2'd1, 0, 6'h3F, 6'h20);
        issue(mk(3, 4'hF, 7) ^ 32'h0000_1000, 1, 2'd1, 0, 6'h3F, 6'h20);
        issue(mk(3, 4'hF, 7) ^ 32'h0010_0000, 1, 2'd1, 0, 6'h3F, 6'h20);
        issue(mk(3, 4'hF, 7), 0, 2'd1, 0, 6'h3F, 6'h20);
        // Sweep op1, op2, CRm at every level under several feature sets (R3..R10, R13)
        foreach (feat_pat[fi]) begin
            for (int el = 0; el < 4; el++)
                for (int o1 = 0; o1 < 8; o1++)
                    for (int o2 = 0; o2 < 8; o2++)
                        for (int c = 0; c < 16; c++)
                            issue(mk(3'(o1), 4'(c), 3'(o2)), 1, 2'(el), fi[0],
                                  feat_pat[fi], 6'h20);
        end
        // R11, R12: every trap-control combination at level 0, set then clear
        for (int cfg = 0; cfg < 64; cfg++) begin
            issue(mk(3, 4'b0101, 6), 1, 2'd0, 0, 6'h3F, 6'(cfg));
            issue(mk(3, 4'b0011, 7), 1, 2'd0, 0, 6'h3F, 6'(cfg));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    logic [5:0] feat_pat [4] = '{6'h3F, 6'h00, 6'h15, 6'h2A};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule